// File: doc/BRIEF.md
# Overlay Window Pixel Fetcher

This block draws a second overlay window on a tile-based display, next to the ordinary background window. The window's left and top edges come from two 8-bit position registers on a small register bus. For every pixel coordinate that the display timing supplies, the block tests whether the pixel lies inside the window. It then looks up a map byte and a tile row in the second video RAM bank and returns a 2-bit colour index, a 3-bit palette index and an active flag.

The map is 32 entries wide. Each map byte carries a palette index in its upper three bits and a tile number in its lower five bits, so only tiles 0 to 31 can be used. A tile is 8x8 pixels at 2 bits per pixel. Each tile row takes two bytes: the low bitplane first, then the high bitplane. Lookups are pipelined, so a new coordinate can be accepted on every clock. The window has an effect only while the privileged-mode input is high. The registers can be read and written at any time.

Top module: `ovl_win_fetch`

## Requirements
- R1: `reg_addr` 0 selects the X position register and 1 selects the Y position register. A write with `reg_we` high takes effect at the clock edge. `reg_rdata` shows the selected register combinationally, whatever the level of `priv_en`.
- R2: A coordinate sampled while `priv_en` is low gives an inactive pixel.
- R3: A coordinate (x, y) hits the window exactly when x + 7 >= X and y >= Y, with both registers taken as unsigned.
- R4: `map_addr` is $1800 + 32*row + col, where row = (y - Y) >> 3 and col = ((x + 7 - X) >> 3) mod 32. It is driven combinationally in the cycle the coordinate is applied.
- R5: `map_data` is expected one cycle after `map_addr`. Its bits 7..5 give the palette index and bits 4..0 give the tile number.
- R6: In the next cycle, `tile_addr` is $1000 + 16*tile + 2*((y - Y) mod 8), which is always even. `tile_data` arrives one cycle later, with the low-plane byte in bits 7..0 and the high-plane byte in bits 15..8.
- R7: With f = (x + 7 - X) mod 8, the colour index is {high[7-f], low[7-f]}, so the leftmost pixel of a tile row is bit 7. The palette output is the palette index from the map entry.
- R8: A coordinate sampled at clock edge n appears on the outputs after edge n+2. A register write at edge n affects only coordinates sampled after edge n.
- R9: Reset clears both position registers and all pixel outputs.
- R10: Whenever `win_active` is low, `win_pal` and `win_clr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_en | input | 1 | Privileged mode; the window is shown only while this is high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 = X, 1 = Y |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Contents of the selected register |
| pix_x | input | 8 | Current screen X |
| pix_y | input | 8 | Current screen Y |
| map_addr | output | 13 | Bank-relative map byte address |
| map_data | input | 8 | Map byte, one cycle after its address |
| tile_addr | output | 13 | Bank-relative address of a tile row (low-plane byte) |
| tile_data | input | 16 | Tile row {high plane, low plane}, one cycle after its address |
| win_active | output | 1 | Pixel lies in the enabled window |
| win_pal | output | 3 | Palette index |
| win_clr | output | 2 | Colour index |

## Verification
The bench builds the block with its default parameters: the map base at $1800, the tile base at $1000 and a left-edge lead of 7. Because of the 7-pixel lead, the window offset can exceed 255 when X is small. This lets the bench scan into the column that wraps back to map entry 0, test the window placed at X = 0 and at X = 255, and walk the exact first-hit column and row. The bench memories hold distinct bytes at every map and tile location, so a wrong row, column, plane or bit order shows up as a colour or palette mismatch.

// File: rtl/ovl_win_pkg.sv
package ovl_win_pkg;

    localparam int CRD_W      = 8;
    localparam int FINE_W     = 3;
    localparam int MAPC_W     = 5;
    localparam int PAL_W      = 3;
    localparam int TILE_W     = CRD_W - PAL_W;
    localparam int CLR_W      = 2;
    localparam int VA_W       = 13;
    localparam int PLANE_W    = 8;
    localparam int ROW_W      = 2 * PLANE_W;
    localparam int TILE_BYTES = 2 << FINE_W;
    localparam int MAP_SPAN   = 1 << (2 * MAPC_W);
    localparam int TILE_SPAN  = TILE_BYTES << TILE_W;

    typedef struct packed {
        logic              hit;
        logic [FINE_W-1:0] fx;
        logic [FINE_W-1:0] fy;
    } loc_t;

    typedef struct packed {
        logic              hit;
        logic [FINE_W-1:0] fx;
        logic [PAL_W-1:0]  pal;
    } fetch_t;

    typedef struct packed {
        logic [PAL_W-1:0]  pal;
        logic [TILE_W-1:0] tile;
    } map_ent_t;

    typedef struct packed {
        logic              active;
        logic [PAL_W-1:0]  pal;
        logic [CLR_W-1:0]  clr;
    } pix_t;

    function automatic logic [VA_W-1:0] map_index(
        input logic [VA_W-1:0]   base,
        input logic [MAPC_W-1:0] row,
        input logic [MAPC_W-1:0] col
    );
        return base + VA_W'({row, col});
    endfunction

    function automatic logic [VA_W-1:0] pattern_addr(
        input logic [VA_W-1:0]   base,
        input logic [TILE_W-1:0] tile,
        input logic [FINE_W-1:0] fy
    );
        return base + VA_W'({tile, fy, 1'b0});
    endfunction

    function automatic logic [CLR_W-1:0] pick_colour(
        input logic [ROW_W-1:0]  planes,
        input logic [FINE_W-1:0] fx
    );
        logic [FINE_W-1:0] idx;
        idx = FINE_W'(PLANE_W - 1) - fx;
        return {planes[PLANE_W + int'(idx)], planes[int'(idx)]};
    endfunction

endpackage

// File: rtl/ovl_win_regs.sv
module ovl_win_regs
    import ovl_win_pkg::*;
#(
    parameter int NREG = 2,
    parameter int W    = CRD_W,
    localparam int AW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic [W-1:0]  val [NREG]
);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                val[g] <= '0;
            end else if (we && (addr == AW'(g))) begin
                val[g] <= wdata;
            end
        end
    end

    assign rdata = val[addr];

endmodule

// File: rtl/ovl_win_locate.sv
module ovl_win_locate
    import ovl_win_pkg::*;
#(
    parameter logic [VA_W-1:0] MAP_BASE = 13'h1800,
    parameter int              XLEAD    = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             priv_en,
    input  logic [CRD_W-1:0] pix_x,
    input  logic [CRD_W-1:0] pix_y,
    input  logic [CRD_W-1:0] pos_x,
    input  logic [CRD_W-1:0] pos_y,
    output logic [VA_W-1:0]  map_addr,
    output loc_t             loc_q
);

    localparam int EXT_W = CRD_W + 1;

    logic [EXT_W-1:0] x_lead;
    logic [CRD_W-1:0] off_x;
    logic [CRD_W-1:0] off_y;
    logic             in_x;
    logic             in_y;
    loc_t             loc_d;

    always_comb begin
        x_lead = {1'b0, pix_x} + EXT_W'(XLEAD);
        in_x   = x_lead >= {1'b0, pos_x};
        in_y   = pix_y >= pos_y;
        off_x  = x_lead[CRD_W-1:0] - pos_x;
        off_y  = pix_y - pos_y;

        loc_d.hit = priv_en && in_x && in_y;
        loc_d.fx  = off_x[FINE_W-1:0];
        loc_d.fy  = off_y[FINE_W-1:0];

        map_addr = map_index(MAP_BASE,
                             off_y[FINE_W +: MAPC_W],
                             off_x[FINE_W +: MAPC_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            loc_q <= '0;
        end else begin
            loc_q <= loc_d;
        end
    end

endmodule

// File: rtl/ovl_win_shift.sv
module ovl_win_shift
    import ovl_win_pkg::*;
#(
    parameter logic [VA_W-1:0] TILE_BASE = 13'h1000
) (
    input  logic             clk,
    input  logic             rst,
    input  loc_t             loc_q,
    input  logic [7:0]       map_data,
    output logic [VA_W-1:0]  tile_addr,
    input  logic [ROW_W-1:0] tile_data,
    output pix_t             pix_q
);

    map_ent_t ent;
    fetch_t   fetch_d;
    fetch_t   fetch_q;
    pix_t     pix_d;

    always_comb begin
        ent         = map_ent_t'(map_data);
        tile_addr   = pattern_addr(TILE_BASE, ent.tile, loc_q.fy);
        fetch_d.hit = loc_q.hit;
        fetch_d.fx  = loc_q.fx;
        fetch_d.pal = ent.pal;
    end

    always_comb begin
        pix_d = '0;
        if (fetch_q.hit) begin
            pix_d.active = 1'b1;
            pix_d.pal    = fetch_q.pal;
            pix_d.clr    = pick_colour(tile_data, fetch_q.fx);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_q <= '0;
            pix_q   <= '0;
        end else begin
            fetch_q <= fetch_d;
            pix_q   <= pix_d;
        end
    end

endmodule

// File: rtl/ovl_win_fetch.sv
module ovl_win_fetch
    import ovl_win_pkg::*;
#(
    parameter logic [VA_W-1:0] MAP_BASE  = 13'h1800,
    parameter logic [VA_W-1:0] TILE_BASE = 13'h1000,
    parameter int              XLEAD     = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             priv_en,
    input  logic             reg_we,
    input  logic             reg_addr,
    input  logic [CRD_W-1:0] reg_wdata,
    output logic [CRD_W-1:0] reg_rdata,
    input  logic [CRD_W-1:0] pix_x,
    input  logic [CRD_W-1:0] pix_y,
    output logic [VA_W-1:0]  map_addr,
    input  logic [7:0]       map_data,
    output logic [VA_W-1:0]  tile_addr,
    input  logic [ROW_W-1:0] tile_data,
    output logic             win_active,
    output logic [PAL_W-1:0] win_pal,
    output logic [CLR_W-1:0] win_clr
);

    localparam int NREG = 2;
    localparam int SEL_X = 0;
    localparam int SEL_Y = 1;

    logic [CRD_W-1:0] pos [NREG];
    logic [CRD_W-1:0] pos_x;
    logic [CRD_W-1:0] pos_y;
    loc_t             loc_q;
    pix_t             pix_q;

    ovl_win_regs #(
        .NREG (NREG),
        .W    (CRD_W)
    ) i_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .val   (pos)
    );

    assign pos_x = pos[SEL_X];
    assign pos_y = pos[SEL_Y];

    ovl_win_locate #(
        .MAP_BASE (MAP_BASE),
        .XLEAD    (XLEAD)
    ) i_locate (
        .clk      (clk),
        .rst      (rst),
        .priv_en  (priv_en),
        .pix_x    (pix_x),
        .pix_y    (pix_y),
        .pos_x    (pos_x),
        .pos_y    (pos_y),
        .map_addr (map_addr),
        .loc_q    (loc_q)
    );

    ovl_win_shift #(
        .TILE_BASE (TILE_BASE)
    ) i_shift (
        .clk       (clk),
        .rst       (rst),
        .loc_q     (loc_q),
        .map_data  (map_data),
        .tile_addr (tile_addr),
        .tile_data (tile_data),
        .pix_q     (pix_q)
    );

    assign win_active = pix_q.active;
    assign win_pal    = pix_q.pal;
    assign win_clr    = pix_q.clr;

endmodule

// File: rtl/ovl_win_chk.sv
module ovl_win_chk
    import ovl_win_pkg::*;
#(
    parameter logic [VA_W-1:0] MAP_BASE  = 13'h1800,
    parameter logic [VA_W-1:0] TILE_BASE = 13'h1000,
    parameter int              XLEAD     = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             priv_en,
    input logic             reg_we,
    input logic             reg_addr,
    input logic [CRD_W-1:0] reg_wdata,
    input logic [CRD_W-1:0] pos_x,
    input logic [CRD_W-1:0] pos_y,
    input logic [CRD_W-1:0] pix_x,
    input logic [CRD_W-1:0] pix_y,
    input logic [VA_W-1:0]  map_addr,
    input logic [VA_W-1:0]  tile_addr,
    input logic             win_active,
    input logic [PAL_W-1:0] win_pal,
    input logic [CLR_W-1:0] win_clr
);

    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst) begin
            age <= '0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    assert_wr_x_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(reg_we) && $past(reg_addr) == 1'b0)
            |-> pos_x == $past(reg_wdata));

    assert_wr_y_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(reg_we) && $past(reg_addr) == 1'b1)
            |-> pos_y == $past(reg_wdata));

    // Output seen at an edge belongs to the coordinate sampled three edges earlier.
    assert_priv_gate_R2: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && !$past(priv_en, 3)) |-> !win_active);

    assert_above_top_R3: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && $past(pix_y, 3) < $past(pos_y, 3)) |-> !win_active);

    assert_left_of_edge_R3: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && (int'($past(pix_x, 3)) + XLEAD < int'($past(pos_x, 3))))
            |-> !win_active);

    assert_map_range_R4: assert property (@(posedge clk) disable iff (rst)
        (int'(map_addr) >= int'(MAP_BASE)) &&
        (int'(map_addr) <  int'(MAP_BASE) + MAP_SPAN));

    assert_tile_row_R6: assert property (@(posedge clk) disable iff (rst)
        !tile_addr[0] &&
        (int'(tile_addr) >= int'(TILE_BASE)) &&
        (int'(tile_addr) <  int'(TILE_BASE) + TILE_SPAN));

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !win_active |-> (win_pal == '0 && win_clr == '0));

endmodule

bind ovl_win_fetch ovl_win_chk #(
    .MAP_BASE  (MAP_BASE),
    .TILE_BASE (TILE_BASE),
    .XLEAD     (XLEAD)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .priv_en    (priv_en),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .pos_x      (pos_x),
    .pos_y      (pos_y),
    .pix_x      (pix_x),
    .pix_y      (pix_y),
    .map_addr   (map_addr),
    .tile_addr  (tile_addr),
    .win_active (win_active),
    .win_pal    (win_pal),
    .win_clr    (win_clr)
);

// File: tb/test_ovl_win_fetch.sv
module test_ovl_win_fetch;

    localparam int CLK_PERIOD = 10;
    localparam int MAP_BASE   = 'h1800;
    localparam int TILE_BASE  = 'h1000;
    localparam int XL         = 7;

    logic        clk = 1'b0;
    logic        rst;
    logic        priv_en;
    logic        reg_we;
    logic        reg_addr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic [7:0]  pix_x;
    logic [7:0]  pix_y;
    logic [12:0] map_addr;
    logic [7:0]  map_data;
    logic [12:0] tile_addr;
    logic [15:0] tile_data;
    logic        win_active;
    logic [2:0]  win_pal;
    logic [1:0]  win_clr;

    int errors = 0;
    int checks = 0;
    int mx = 0;
    int my = 0;
    int exp_q[$];

    logic [7:0] map_mem  [1024];
    logic [7:0] tile_mem [512];

    always #(CLK_PERIOD / 2) clk = ~clk;

    ovl_win_fetch i_ovl_win_fetch (
        .clk        (clk),
        .rst        (rst),
        .priv_en    (priv_en),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .pix_x      (pix_x),
        .pix_y      (pix_y),
        .map_addr   (map_addr),
        .map_data   (map_data),
        .tile_addr  (tile_addr),
        .tile_data  (tile_data),
        .win_active (win_active),
        .win_pal    (win_pal),
        .win_clr    (win_clr)
    );

    // Synchronous bank-1 memory model: one cycle of read latency.
    always @(posedge clk) begin
        int ma;
        int ta;
        ma = int'(map_addr) - MAP_BASE;
        ta = int'(tile_addr) - TILE_BASE;
        map_data  <= (ma >= 0 && ma < 1024) ? map_mem[ma] : 8'h00;
        tile_data <= (ta >= 0 && ta < 511) ? {tile_mem[ta + 1], tile_mem[ta]} : 16'h0000;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected {active, palette, colour} packed as active*32 + pal*4 + clr.
    function automatic int model_pix(input bit pv, input int x, input int y);
        int dx;
        int dy;
        int ent;
        int tb;
        int lo;
        int hi;
        int b;
        dx = x + XL - mx;
        dy = y - my;
        if (!pv || dx < 0 || dy < 0) return 0;
        ent = int'(map_mem[((dy / 8) % 32) * 32 + (dx / 8) % 32]);
        tb  = (ent % 32) * 16 + (dy % 8) * 2;
        lo  = int'(tile_mem[tb]);
        hi  = int'(tile_mem[tb + 1]);
        b   = 7 - (dx % 8);
        return 32 + (ent / 32) * 4 + ((hi >> b) & 1) * 2 + ((lo >> b) & 1);
    endfunction

    // Apply one pixel (and optional register write); compare output two edges later (R8).
    task automatic step(input bit pv, input int x, input int y,
                        input bit we, input bit a, input int d, input string req);
        int e;
        int act;
        priv_en   = pv;
        pix_x     = 8'(x);
        pix_y     = 8'(y);
        reg_we    = we;
        reg_addr  = a;
        reg_wdata = 8'(d);
        @(posedge clk);
        @(negedge clk);
        e = model_pix(pv, x, y);
        if (we) begin
            if (a) my = d; else mx = d;
        end
        exp_q.push_back(e);
        e   = exp_q.pop_front();
        act = int'(win_active) * 32 + int'(win_pal) * 4 + int'(win_clr);
        check(act == e, req, act, e);
        reg_we = 1'b0;
    endtask

    task automatic read_reg(input bit a, input int exp, input string req);
        reg_addr = a;
        #1;
        check(int'(reg_rdata) == exp, req, int'(reg_rdata), exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) map_mem[i] = 8'((i * 37 + 11) ^ (i >> 5));
        for (int i = 0; i < 512; i++)  tile_mem[i] = 8'((i * 73 + 5) ^ (i >> 3));

        rst = 1'b1; priv_en = 1'b0; reg_we = 1'b0; reg_addr = 1'b0;
        reg_wdata = '0; pix_x = '0; pix_y = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state of outputs and registers
        check(win_active == 1'b0 && win_pal == 3'd0 && win_clr == 2'd0, "R9 outputs",
              int'({win_active, win_pal, win_clr}), 0);
        read_reg(1'b0, 0, "R9 X reg");
        read_reg(1'b1, 0, "R9 Y reg");
        rst = 1'b0;
        exp_q.push_back(0);
        exp_q.push_back(0);

        // R1: writes and readback while not privileged
        step(1'b0, 0, 0, 1'b1, 1'b0, 100, "R1 write X");
        step(1'b0, 0, 0, 1'b1, 1'b1, 50, "R1 write Y");
        read_reg(1'b0, 100, "R1 X readback");
        read_reg(1'b1, 50, "R1 Y readback");

        // R2: not privileged, window would otherwise cover these pixels
        for (int x = 88; x < 130; x++) step(1'b0, x, 60, 1'b0, 1'b0, 0, "R2 gated");

        // R3: exact left and top edges (X=100 -> first x is 93; Y=50)
        for (int y = 48; y < 53; y++)
            for (int x = 88; x < 110; x++) step(1'b1, x, y, 1'b0, 1'b0, 0, "R3 edge");

        // R4 R5 R6 R7: window at origin, several rows of tiles
        step(1'b1, 0, 0, 1'b1, 1'b0, 0, "R1 X to 0");
        step(1'b1, 0, 0, 1'b1, 1'b1, 0, "R1 Y to 0");
        for (int y = 0; y < 18; y++)
            for (int x = 0; x < 40; x++) step(1'b1, x, y, 1'b0, 1'b0, 0, "R7 decode");

        // R4: column wrap, offset x+7 reaches 262 -> column 32 wraps to 0
        for (int x = 236; x < 256; x++) step(1'b1, x, 200, 1'b0, 1'b0, 0, "R4 wrap");

        // R3: X=7 makes x=0 the first covered pixel
        step(1'b1, 0, 0, 1'b1, 1'b0, 7, "R1 X to 7");
        for (int x = 0; x < 20; x++) step(1'b1, x, 9, 1'b0, 1'b0, 0, "R3 x7");

        // R3: corner at 255/255
        step(1'b1, 0, 0, 1'b1, 1'b0, 255, "R1 X to 255");
        step(1'b1, 0, 0, 1'b1, 1'b1, 255, "R1 Y to 255");
        for (int y = 253; y < 256; y++)
            for (int x = 244; x < 256; x++) step(1'b1, x, y, 1'b0, 1'b0, 0, "R3 corner");
        read_reg(1'b0, 255, "R1 X corner");

        // R8: write during a scan affects only later pixels
        step(1'b1, 0, 0, 1'b1, 1'b1, 20, "R1 Y to 20");
        for (int x = 0; x < 60; x++)
            step(1'b1, x, 33, (x == 25), 1'b0, 30, "R8 mid-scan write");

        // R2 R8: privilege toggling each pixel
        for (int x = 30; x < 80; x++)
            step(x[0], x, 40, 1'b0, 1'b0, 0, "R2 toggle");

        // drain
        for (int k = 0; k < 3; k++) step(1'b0, 0, 0, 1'b0, 1'b0, 0, "R10 drain");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule